// File: doc/BRIEF.md
# Video Memory Port Address Generator

This block produces the byte address for a video memory port that a processor reaches through I/O accesses. It keeps two pointers, one for reads and one for writes. A program can therefore copy data byte by byte between two regions of video memory without reloading an address between transfers. Each pointer has its own mode, which selects whether it counts up or down after an access. The mode can also enable a windowed walk. In that walk the pointer steps through a run of bytes, then adds a programmable stride to reach the next line of a rectangle.

Configuration arrives as byte writes on a small register port. Each data-port access asserts a strobe, and a qualifier marks it as a read or a write. During the strobe cycle the block drives the address of the pointer chosen by that qualifier, together with a valid flag. The pointer then moves on at the next clock edge. The memory array and the display timing are not part of this block.

Top module: `vram_addr_gen`

## Requirements
- R1: After reset, both pointers and both modes are zero, so the first access of either kind presents address 0 and the next one presents 1. The outputs are mem_valid = 0 and mem_addr = 0.
- R2: mem_valid equals acc_stb. During a strobe cycle mem_addr shows the write pointer when acc_wr = 1 and the read pointer when acc_wr = 0. With no strobe, mem_addr is 0.
- R3: Each address byte is loaded on its own through cfg_sel, and the other bytes keep their values. Read pointer: 0 = bits 7:0, 1 = bits 15:8, 2 = bit 16 (taken from cfg_data bit 0). Write pointer: 4, 5 and 6, with the same layout.
- R4: A read access steps only the read pointer, and a write access steps only the write pointer.
- R5: Mode registers are selected by cfg_sel 3 (read) and 7 (write). Bit 0 of the mode gives the direction: 0 steps by +1 after each access, 1 steps by -1. Writing a mode register leaves the pointer value unchanged.
- R6: Pointer arithmetic wraps modulo 2^17. Stepping up from 0x1FFFF gives 0, and stepping down from 0 gives 0x1FFFF.
- R7: Mode bit 1 enables the windowed walk. The run length N is at cfg_sel 8, and the stride is at cfg_sel 9, 10 and 11 (same byte layout as R3). The first N-1 accesses of a run take the normal step. The Nth access adds the stride instead, and a new run begins.
- R8: When N = 0, a pointer with windowed mode enabled takes the plain step on every access.
- R9: If a pointer's address byte or mode register is written in the same cycle as an access to that pointer, the write takes effect and the step for that access is dropped. The output in that cycle still shows the pointer's old value.
- R10: Writing an address byte or the mode register of a pointer reloads that pointer's run count to N, so a full run of N accesses follows before the next stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| acc_stb | input | 1 | Data-port access strobe |
| acc_wr | input | 1 | Access kind: 1 = write, 0 = read |
| mem_addr | output | 17 | Memory address for the current access |
| mem_valid | output | 1 | Address valid (an access is in progress) |

## Verification
The hardest case to reach from the ports is a load that coincides with an access to the same pointer, combined with a run count that depends on the history of earlier loads. A stride can only be seen after exactly N accesses, so the bench first fixes N, the stride and a start address. It then walks a line end, and reloads a pointer part-way through a run to show that the count restarts. A single vector applies a low-byte load and a read strobe in the same cycle. The next read shows the loaded value with no step applied.

// File: rtl/vag_pkg.sv
package vag_pkg;
  localparam int ADDR_W = 17;
  localparam int RUN_W  = 8;
  localparam int SEL_W  = 4;
  localparam int NBYTES = (ADDR_W + 7) / 8;
  localparam int NPTR   = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [RUN_W-1:0]  run_t;

  // bit 1 = windowed enable, bit 0 = count down
  typedef struct packed {
    logic win;
    logic down;
  } mode_t;

  function automatic logic win_on(mode_t m, run_t n);
    return m.win && (n != '0);
  endfunction

  function automatic logic run_ends(mode_t m, run_t n, run_t c);
    return win_on(m, n) && (c <= run_t'(1));
  endfunction

  function automatic addr_t next_addr(addr_t a, mode_t m, logic jump, addr_t s);
    if (jump)        return a + s;
    else if (m.down) return a - addr_t'(1);
    else             return a + addr_t'(1);
  endfunction

  function automatic run_t next_count(mode_t m, run_t n, run_t c);
    if (!win_on(m, n))        return c;
    else if (c <= run_t'(1))  return n;
    else                      return c - run_t'(1);
  endfunction
endpackage

// File: rtl/vag_cfg_decode.sv
module vag_cfg_decode
  import vag_pkg::*;
(
  input  logic                         cfg_we,
  input  logic [SEL_W-1:0]             cfg_sel,
  output logic [NPTR-1:0][NBYTES-1:0]  ptr_byte_we,
  output logic [NPTR-1:0]              ptr_mode_we,
  output logic                         run_we,
  output logic [NBYTES-1:0]            stride_byte_we
);
  // each pointer owns NBYTES address selects followed by one mode select
  localparam int PTR_SPAN = NBYTES + 1;
  localparam int RUN_SEL  = NPTR * PTR_SPAN;
  localparam int STR_BASE = RUN_SEL + 1;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      assign ptr_byte_we[p][i] = cfg_we && (cfg_sel == SEL_W'(p * PTR_SPAN + i));
    end
    assign ptr_mode_we[p] = cfg_we && (cfg_sel == SEL_W'(p * PTR_SPAN + NBYTES));
  end

  assign run_we = cfg_we && (cfg_sel == SEL_W'(RUN_SEL));

  for (genvar i = 0; i < NBYTES; i++) begin : g_stride
    assign stride_byte_we[i] = cfg_we && (cfg_sel == SEL_W'(STR_BASE + i));
  end
endmodule

// File: rtl/vag_pointer.sv
module vag_pointer
  import vag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] byte_we,
  input  logic              mode_we,
  input  logic [7:0]        wdata,
  input  logic              access,
  input  run_t              run_len,
  input  addr_t             stride,
  output addr_t             ptr,
  output run_t              cnt,
  output mode_t             mode,
  output logic              load
);
  addr_t ptr_n;
  run_t  cnt_n;

  assign load = (|byte_we) || mode_we;

  always_comb begin
    ptr_n = ptr;
    for (int b = 0; b < ADDR_W; b++) begin
      if (byte_we[b / 8]) ptr_n[b] = wdata[b % 8];
    end
    if (!load && access)
      ptr_n = next_addr(ptr, mode, run_ends(mode, run_len, cnt), stride);
  end

  always_comb begin
    if (load)        cnt_n = run_len;
    else if (access) cnt_n = next_count(mode, run_len, cnt);
    else             cnt_n = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      cnt  <= '0;
      mode <= '0;
    end else begin
      ptr <= ptr_n;
      cnt <= cnt_n;
      if (mode_we) mode <= mode_t'(wdata[1:0]);
    end
  end
endmodule

// File: rtl/vram_addr_gen.sv
module vram_addr_gen
  import vag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_data,
  input  logic             acc_stb,
  input  logic             acc_wr,
  output addr_t            mem_addr,
  output logic             mem_valid
);
  localparam int RD = 0;
  localparam int WR = 1;

  logic [NPTR-1:0][NBYTES-1:0] ptr_byte_we;
  logic [NPTR-1:0]             ptr_mode_we;
  logic                        run_we;
  logic [NBYTES-1:0]           stride_byte_we;

  run_t  run_len;
  addr_t stride;
  addr_t stride_n;

  addr_t [NPTR-1:0] ptr_q;
  run_t  [NPTR-1:0] cnt_q;
  mode_t [NPTR-1:0] mode_q;
  logic  [NPTR-1:0] load_q;
  logic  [NPTR-1:0] acc_q;

  vag_cfg_decode u_dec (
    .cfg_we         (cfg_we),
    .cfg_sel        (cfg_sel),
    .ptr_byte_we    (ptr_byte_we),
    .ptr_mode_we    (ptr_mode_we),
    .run_we         (run_we),
    .stride_byte_we (stride_byte_we)
  );

  assign acc_q[RD] = acc_stb && !acc_wr;
  assign acc_q[WR] = acc_stb && acc_wr;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    vag_pointer u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_we (ptr_byte_we[p]),
      .mode_we (ptr_mode_we[p]),
      .wdata   (cfg_data),
      .access  (acc_q[p]),
      .run_len (run_len),
      .stride  (stride),
      .ptr     (ptr_q[p]),
      .cnt     (cnt_q[p]),
      .mode    (mode_q[p]),
      .load    (load_q[p])
    );
  end

  always_comb begin
    stride_n = stride;
    for (int b = 0; b < ADDR_W; b++) begin
      if (stride_byte_we[b / 8]) stride_n[b] = cfg_data[b % 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      stride  <= '0;
    end else begin
      if (run_we) run_len <= cfg_data;
      stride <= stride_n;
    end
  end

  // named internal events for the checker
  addr_t rd_ptr, wr_ptr;
  run_t  rd_cnt, wr_cnt;
  mode_t rd_mode, wr_mode;
  logic  rd_load, wr_load;
  assign rd_ptr  = ptr_q[RD];
  assign wr_ptr  = ptr_q[WR];
  assign rd_cnt  = cnt_q[RD];
  assign wr_cnt  = cnt_q[WR];
  assign rd_mode = mode_q[RD];
  assign wr_mode = mode_q[WR];
  assign rd_load = load_q[RD];
  assign wr_load = load_q[WR];

  assign mem_valid = acc_stb;
  assign mem_addr  = acc_stb ? (acc_wr ? wr_ptr : rd_ptr) : '0;
endmodule

// File: rtl/vag_checker.sv
module vag_checker
  import vag_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  acc_stb,
  input logic  acc_wr,
  input logic  rd_load,
  input logic  wr_load,
  input addr_t rd_ptr,
  input addr_t wr_ptr,
  input run_t  rd_cnt,
  input run_t  wr_cnt,
  input run_t  run_len,
  input mode_t rd_mode,
  input mode_t wr_mode
);
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_wr && !rd_load) |=> $stable(rd_ptr));

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_wr && !wr_load) |=> $stable(wr_ptr));

  p_rd_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_wr && !rd_load && rd_mode == 2'b00)
      |=> rd_ptr == addr_t'($past(rd_ptr) + addr_t'(1)));

  p_rd_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_wr && !rd_load && rd_mode == 2'b01)
      |=> rd_ptr == addr_t'($past(rd_ptr) - addr_t'(1)));

  p_rd_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> rd_cnt == $past(run_len));

  p_wr_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> wr_cnt == $past(run_len));

  p_wr_mode_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_stb && !wr_load) |=> $stable(wr_ptr) && $stable(wr_mode));
endmodule

bind vram_addr_gen vag_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .acc_stb (acc_stb),
  .acc_wr  (acc_wr),
  .rd_load (rd_load),
  .wr_load (wr_load),
  .rd_ptr  (rd_ptr),
  .wr_ptr  (wr_ptr),
  .rd_cnt  (rd_cnt),
  .wr_cnt  (wr_cnt),
  .run_len (run_len),
  .rd_mode (rd_mode),
  .wr_mode (wr_mode)
);

// File: tb/test_vram_addr_gen.sv
module test_vram_addr_gen;
  localparam int PERIOD = 10;
  localparam int NVEC = 57;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        acc_stb = 1'b0;
  logic        acc_wr = 1'b0;
  logic [16:0] mem_addr;
  logic        mem_valid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  vram_addr_gen i_vram_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .acc_stb(acc_stb), .acc_wr(acc_wr),
    .mem_addr(mem_addr), .mem_valid(mem_valid)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  sel;
    logic [7:0]  dat;
    logic        stb;
    logic        wr;
    logic [16:0] exp;
    logic [3:0]  req;
  } vec_t;

  // cfg row: {1,sel,data,0,0,0,req}; access row: {0,0,0,1,wr,expected,req}
  localparam vec_t VEC [NVEC] = '{
    {1'b1,4'd0,8'h34,1'b0,1'b0,17'h0,4'd3},      // R3 rd low
    {1'b1,4'd1,8'h12,1'b0,1'b0,17'h0,4'd3},      // R3 rd mid
    {1'b1,4'd2,8'h01,1'b0,1'b0,17'h0,4'd2},      // R2 idle
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h11234,4'd2},  // R2 read shows rd ptr
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h11235,4'd5},  // R5 up
    {1'b1,4'd4,8'hFF,1'b0,1'b0,17'h0,4'd3},
    {1'b1,4'd5,8'hFF,1'b0,1'b0,17'h0,4'd3},
    {1'b1,4'd6,8'h01,1'b0,1'b0,17'h0,4'd3},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h1FFFF,4'd4},  // R4 write shows wr ptr
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00000,4'd6},  // R6 wrap up
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h11236,4'd4},  // R4 rd untouched by writes
    {1'b1,4'd0,8'h00,1'b0,1'b0,17'h0,4'd3},
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h11200,4'd3},  // R3 only low byte changed
    {1'b1,4'd3,8'h01,1'b0,1'b0,17'h0,4'd5},      // rd down
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h11201,4'd5},  // R5 mode write keeps ptr
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h11200,4'd5},  // R5 down
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00001,4'd4},  // R4 wr still up
    {1'b1,4'd4,8'h00,1'b0,1'b0,17'h0,4'd3},
    {1'b1,4'd5,8'h00,1'b0,1'b0,17'h0,4'd3},
    {1'b1,4'd6,8'h00,1'b0,1'b0,17'h0,4'd3},
    {1'b1,4'd7,8'h01,1'b0,1'b0,17'h0,4'd5},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00000,4'd6},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h1FFFF,4'd6},  // R6 wrap down
    {1'b1,4'd8,8'h03,1'b0,1'b0,17'h0,4'd7},      // N = 3
    {1'b1,4'd9,8'h10,1'b0,1'b0,17'h0,4'd7},      // stride 0x10
    {1'b1,4'd10,8'h00,1'b0,1'b0,17'h0,4'd7},
    {1'b1,4'd11,8'h00,1'b0,1'b0,17'h0,4'd7},
    {1'b1,4'd7,8'h02,1'b0,1'b0,17'h0,4'd7},      // wr windowed up
    {1'b1,4'd4,8'h00,1'b0,1'b0,17'h0,4'd7},
    {1'b1,4'd5,8'h02,1'b0,1'b0,17'h0,4'd7},
    {1'b1,4'd6,8'h00,1'b0,1'b0,17'h0,4'd7},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00200,4'd7},  // R7
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00201,4'd7},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00202,4'd7},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00212,4'd7},  // R7 stride
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00213,4'd7},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00214,4'd7},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00224,4'd7},
    {1'b1,4'd8,8'h00,1'b0,1'b0,17'h0,4'd8},      // N = 0
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00225,4'd8},  // R8
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00226,4'd8},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00227,4'd8},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00228,4'd8},
    {1'b1,4'd0,8'h50,1'b1,1'b0,17'h111FF,4'd9},  // R9 load + read same cycle
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h11150,4'd9},  // R9 step dropped
    {1'b0,4'd0,8'h00,1'b1,1'b0,17'h1114F,4'd5},
    {1'b1,4'd8,8'h02,1'b0,1'b0,17'h0,4'd10},     // N = 2
    {1'b1,4'd9,8'h00,1'b0,1'b0,17'h0,4'd10},     // stride 0x100
    {1'b1,4'd10,8'h01,1'b0,1'b0,17'h0,4'd10},
    {1'b1,4'd7,8'h02,1'b0,1'b0,17'h0,4'd10},     // mode write reloads count
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h00229,4'd10},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h0022A,4'd10},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h0032A,4'd10}, // R10 stride after 2
    {1'b1,4'd4,8'h2B,1'b0,1'b0,17'h0,4'd10},     // mid-run reload
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h0032B,4'd10}, // R10 full run again
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h0032C,4'd10},
    {1'b0,4'd0,8'h00,1'b1,1'b1,17'h0042C,4'd10}
  };

  task automatic check(input int req, input logic v, input logic [16:0] a,
                       input logic ev, input logic [16:0] ea);
    checks++;
    if (v !== ev || a !== ea) begin
      fails++;
      $display("FAIL R%0d: valid=%0b addr=%05h expected valid=%0b addr=%05h",
               req, v, a, ev, ea);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] sel, input logic [7:0] dat,
                       input logic stb, input logic wr);
    cfg_we = we; cfg_sel = sel; cfg_data = dat; acc_stb = stb; acc_wr = wr;
    #1;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 4'd0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected under 20000", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(1, mem_valid, mem_addr, 1'b0, 17'h0);            // R1 outputs in reset
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
    check(1, mem_valid, mem_addr, 1'b1, 17'h0);            // R1 rd ptr zero
    finish_cycle();

    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k].we, VEC[k].sel, VEC[k].dat, VEC[k].stb, VEC[k].wr);
      check(int'(VEC[k].req), mem_valid, mem_addr, VEC[k].stb, VEC[k].exp);
      finish_cycle();
    end

    // R1: reset mid-run clears pointers and modes
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 4'd0, 8'h00, 1'b1, 1'b1);
    check(1, mem_valid, mem_addr, 1'b1, 17'h0);            // R1 wr ptr zero
    finish_cycle();
    drive(1'b0, 4'd0, 8'h00, 1'b1, 1'b1);
    check(1, mem_valid, mem_addr, 1'b1, 17'h1);            // R1 wr mode up
    finish_cycle();
    drive(1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
    check(1, mem_valid, mem_addr, 1'b1, 17'h0);            // R1 rd ptr zero
    finish_cycle();
    drive(1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
    check(1, mem_valid, mem_addr, 1'b1, 17'h1);            // R1 rd mode up
    finish_cycle();

    done = 1;
    summary();
  end
endmodule